// File: doc/BRIEF.md
# Dual-Device DDR Quad-SPI Stream Reader

This block pulls an unbounded byte stream out of two quad-SPI flash devices that share one clock and one chip select. A single request supplies a start address and a dummy-cycle count. The engine drives the read command and the address to both devices on the shared quad output lines, one nibble per rising flash clock edge. It then waits the requested number of dummy clocks and enters a double-data-rate data phase. In that phase it samples both 4-bit input buses on every flash clock edge, rising and falling alike.

Every sampling edge yields 8 bits, one nibble from each device. Four consecutive edges form one 32-bit word, which is pushed into a small buffer and offered to a consumer through a valid/ready port. The flash clock runs at half the system clock, so a stream with no back-pressure delivers one word every four system clocks. At a 66 MHz flash clock this amounts to roughly 132 MB/s. When the buffer is full at a word boundary, the engine parks the flash clock low and keeps chip select asserted, so no data is lost. A stop request ends the transfer at the next word boundary.

The control state machine has five states. IDLE waits for a request. PREAMBLE shifts out the command and the address. DUMMY counts the wait clocks. STREAM samples data. HOLD parks the clock while the buffer is full. The transitions are:
- IDLE→PREAMBLE when a request is accepted.
- PREAMBLE→DUMMY after the last preamble falling edge, or PREAMBLE→STREAM at that point when the count is zero.
- DUMMY→STREAM after the last dummy falling edge.
- STREAM→HOLD at a word boundary with a full buffer, and HOLD→STREAM once a slot frees.
- STREAM→IDLE or HOLD→IDLE at a word boundary while a stop is pending.

Top module: `ddr_qspi_reader`

## Requirements
- R1: After reset, fl_cs_n=1, fl_sck=0, fl_dq_oe=0, out_valid=0 and req_ready=1.
- R2: req_ready is high only in IDLE, and a request is taken when req_valid and req_ready are both high. Chip select then falls and the engine shifts out the 8-bit READ_CMD (default 8'hED) followed by the ADDR_W-bit address, most significant nibble first. Each nibble is on fl_dq_o with fl_dq_oe high at a rising fl_sck edge. fl_sck toggles on every system clock in this phase.
- R3: After the last preamble falling edge, fl_dq_oe is low and exactly req_dummy further full flash clock cycles pass before the data phase. A count of 0 goes straight to data.
- R4: In the data phase, fl_dqa_i and fl_dqb_i are both sampled just before every fl_sck transition, rising and falling, so each edge contributes 8 bits.
- R5: Each device byte arrives upper nibble first. Word j is {B[2j+1], A[2j+1], B[2j], A[2j]}, where A[k] and B[k] are the k-th bytes streamed by device A and device B. Bits 7:0 hold A[2j] (little-endian).
- R6: The stream has no length limit. With out_ready held high, exactly one word is delivered per four system clocks in steady state.
- R7: Words leave in stream order. While out_valid is high and out_ready low, out_valid and out_data stay unchanged.
- R8: The buffer holds BUF_DEPTH (default 4) words. When it is full at a word boundary, fl_sck is held low and fl_cs_n stays low until space frees. No word is dropped, and exactly 4·BUF_DEPTH data edges are taken before the stall.
- R9: A stop_req pulse in any non-idle state deasserts chip select at the next word boundary, so the number of data edges is a multiple of 4. The engine returns to IDLE and words already buffered are still delivered.
- R10: req_valid while the engine is busy is ignored. Chip select does not re-fall and the running stream continues unchanged.
- R11: fl_sck is low whenever fl_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | ADDR_W | Start address sent in the preamble |
| req_dummy | input | DUMMY_W | Number of dummy flash clock cycles |
| stop_req | input | 1 | End the stream at the next word boundary |
| fl_sck | output | 1 | Shared flash clock |
| fl_cs_n | output | 1 | Shared active-low chip select |
| fl_dq_o | output | 4 | Command/address nibble to both devices |
| fl_dq_oe | output | 1 | Output enable for fl_dq_o |
| fl_dqa_i | input | 4 | Data nibble from device A |
| fl_dqb_i | input | 4 | Data nibble from device B |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Packed data word |

## Verification
The hardest case to reach from the ports is the parked clock. It needs the buffer to fill exactly at a word boundary while chip select stays low, and then the stream must resume without a lost or repeated nibble. The bench models both devices, which answer on every flash clock edge. It starts a stream with out_ready low and waits until the clock stops. It then checks that exactly sixteen data edges were taken and that fl_sck no longer moves. Finally it releases the consumer and lets the scoreboard confirm the word sequence across the stall. Stops requested during the preamble and requests issued mid-stream cover the remaining hard-to-time transitions.

// File: rtl/ddr_qspi_pkg.sv
package ddr_qspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_DUMMY,
        ST_STREAM,
        ST_HOLD
    } phase_e;

    localparam int NIB_W          = 4;
    localparam int WORD_W         = 32;
    localparam int EDGE_BITS      = 2 * NIB_W;
    localparam int EDGES_PER_WORD = WORD_W / EDGE_BITS;
    localparam int EDGE_IDX_W     = $clog2(EDGES_PER_WORD);

endpackage

// File: rtl/ddr_qspi_cmd_shift.sv
module ddr_qspi_cmd_shift
    import ddr_qspi_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter logic [7:0]  READ_CMD = 8'hED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [ADDR_W-1:0] addr,
    output logic [NIB_W-1:0]  nib_o,
    output logic              last_o
);

    localparam int SH_W  = 8 + ADDR_W;
    localparam int NIBS  = SH_W / NIB_W;
    localparam int CNT_W = $clog2(NIBS + 1);

    logic [SH_W-1:0]  sh_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= {READ_CMD, addr};
            cnt_q <= '0;
        end else if (shift) begin
            sh_q  <= sh_q << NIB_W;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign nib_o  = sh_q[SH_W-1 -: NIB_W];
    assign last_o = (cnt_q == CNT_W'(NIBS - 1));

endmodule

// File: rtl/ddr_qspi_packer.sv
module ddr_qspi_packer
    import ddr_qspi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  capture,
    input  logic [NIB_W-1:0]      nib_a,
    input  logic [NIB_W-1:0]      nib_b,
    output logic [EDGE_IDX_W-1:0] edge_idx,
    output logic                  word_done,
    output logic [WORD_W-1:0]     word_o
);

    localparam logic [EDGE_IDX_W-1:0] LAST_EDGE = EDGE_IDX_W'(EDGES_PER_WORD - 1);

    logic [EDGE_IDX_W-1:0] edge_q;
    logic [WORD_W-1:0]     asm_q;
    logic [WORD_W-1:0]     word_nx;

    // Edge e fills byte pair e/2; even edges carry the upper nibbles.
    always_comb begin
        word_nx = asm_q;
        for (int e = 0; e < EDGES_PER_WORD; e++) begin
            if (edge_q == EDGE_IDX_W'(e)) begin
                word_nx[(e/2)*2*EDGE_BITS + ((e%2 == 0) ? NIB_W : 0) +: NIB_W]             = nib_a;
                word_nx[(e/2)*2*EDGE_BITS + EDGE_BITS + ((e%2 == 0) ? NIB_W : 0) +: NIB_W] = nib_b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
            asm_q  <= '0;
        end else if (clear) begin
            edge_q <= '0;
            asm_q  <= '0;
        end else if (capture) begin
            asm_q  <= word_nx;
            edge_q <= (edge_q == LAST_EDGE) ? '0 : edge_q + 1'b1;
        end
    end

    assign edge_idx  = edge_q;
    assign word_done = capture && (edge_q == LAST_EDGE);
    assign word_o    = word_nx;

endmodule

// File: rtl/ddr_qspi_fifo.sv
module ddr_qspi_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             valid,
    output logic             full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign valid   = (cnt_q != '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/ddr_qspi_reader.sv
module ddr_qspi_reader
    import ddr_qspi_pkg::*;
#(
    parameter int         ADDR_W    = 24,
    parameter int         DUMMY_W   = 4,
    parameter int         BUF_DEPTH = 4,
    parameter logic [7:0] READ_CMD  = 8'hED
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DUMMY_W-1:0] req_dummy,
    input  logic               stop_req,
    output logic               fl_sck,
    output logic               fl_cs_n,
    output logic [NIB_W-1:0]   fl_dq_o,
    output logic               fl_dq_oe,
    input  logic [NIB_W-1:0]   fl_dqa_i,
    input  logic [NIB_W-1:0]   fl_dqb_i,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_data
);

    phase_e state_q, state_nx;

    logic               sck_q, cs_n_q, oe_q, stop_q;
    logic [DUMMY_W-1:0] dcnt_q, dummy_q;

    logic                  pre_last, fifo_full, word_done;
    logic [EDGE_IDX_W-1:0] edge_idx;
    logic [WORD_W-1:0]     word;

    logic accept, shift, pre_end, dum_end, boundary, stream_go, toggle, leaving;

    // ---------------- strobes ----------------
    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign shift     = (state_q == ST_PREAMBLE) && sck_q && !pre_last;
    assign pre_end   = (state_q == ST_PREAMBLE) && sck_q && pre_last;
    assign dum_end   = (state_q == ST_DUMMY) && sck_q && (dcnt_q == dummy_q - 1'b1);
    assign boundary  = (edge_idx == '0);
    assign stream_go = (state_q == ST_STREAM) && !(boundary && (stop_q || fifo_full));
    assign toggle    = (state_q == ST_PREAMBLE) || (state_q == ST_DUMMY) || stream_go;
    assign leaving   = (state_q != ST_IDLE) && (state_nx == ST_IDLE);

    // ---------------- sub-blocks ----------------
    ddr_qspi_cmd_shift #(
        .ADDR_W   (ADDR_W),
        .READ_CMD (READ_CMD)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .shift  (shift),
        .addr   (req_addr),
        .nib_o  (fl_dq_o),
        .last_o (pre_last)
    );

    ddr_qspi_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .capture   (stream_go),
        .nib_a     (fl_dqa_i),
        .nib_b     (fl_dqb_i),
        .edge_idx  (edge_idx),
        .word_done (word_done),
        .word_o    (word)
    );

    ddr_qspi_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (BUF_DEPTH)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (word_done),
        .din   (word),
        .pop   (out_ready),
        .dout  (out_data),
        .valid (out_valid),
        .full  (fifo_full)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_nx = ST_PREAMBLE;
            ST_PREAMBLE: if (pre_end) state_nx = (dummy_q == '0) ? ST_STREAM : ST_DUMMY;
            ST_DUMMY:    if (dum_end) state_nx = ST_STREAM;
            ST_STREAM: begin
                if (boundary && stop_q)         state_nx = ST_IDLE;
                else if (boundary && fifo_full) state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (stop_q)          state_nx = ST_IDLE;
                else if (!fifo_full) state_nx = ST_STREAM;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            cs_n_q  <= 1'b1;
            oe_q    <= 1'b0;
            stop_q  <= 1'b0;
            dcnt_q  <= '0;
            dummy_q <= '0;
        end else begin
            if (accept) begin
                cs_n_q  <= 1'b0;
                oe_q    <= 1'b1;
                dummy_q <= req_dummy;
                dcnt_q  <= '0;
            end
            if (pre_end) oe_q <= 1'b0;
            if ((state_q == ST_DUMMY) && sck_q) dcnt_q <= dcnt_q + 1'b1;
            if (toggle) sck_q <= ~sck_q;
            if (leaving) begin
                cs_n_q <= 1'b1;
                stop_q <= 1'b0;
            end else if (accept) begin
                stop_q <= 1'b0;
            end else if (stop_req && (state_q != ST_IDLE)) begin
                stop_q <= 1'b1;
            end
        end
    end

    assign fl_sck    = sck_q;
    assign fl_cs_n   = cs_n_q;
    assign fl_dq_oe  = oe_q;
    assign req_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/ddr_qspi_reader_chk.sv
module ddr_qspi_reader_chk
    import ddr_qspi_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input phase_e                state,
    input logic [EDGE_IDX_W-1:0] edge_idx,
    input logic                  fl_sck,
    input logic                  fl_cs_n,
    input logic                  fl_dq_oe,
    input logic                  req_ready,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [WORD_W-1:0]     out_data
);

    // R2: a request can only be taken while the bus is deselected
    a_r2_ready_only_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> fl_cs_n);

    // R2: the flash clock moves on every system clock of preamble and dummy phases
    a_r2_preamble_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREAMBLE || state == ST_DUMMY) |=> (fl_sck != $past(fl_sck)));

    // R3: the shared lines are released during data sampling
    a_r3_oe_off_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM || state == ST_HOLD) |-> !fl_dq_oe);

    // R7: a refused word is held unchanged
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: parked clock keeps the devices selected
    a_r8_park_low_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (!fl_sck && !fl_cs_n));

    // R9: deselect happens only on a word boundary
    a_r9_stop_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_cs_n) |-> (edge_idx == '0));

    // R11: no clock activity while deselected
    a_r11_sck_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cs_n |-> !fl_sck);

endmodule

bind ddr_qspi_reader ddr_qspi_reader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .edge_idx  (edge_idx),
    .fl_sck    (fl_sck),
    .fl_cs_n   (fl_cs_n),
    .fl_dq_oe  (fl_dq_oe),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/ddr_qspi_reader_tb.sv
module ddr_qspi_reader_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         ADDR_W     = 24;
    localparam int         DUMMY_W    = 4;
    localparam int         DEPTH      = 4;
    localparam logic [7:0] CMD        = 8'hED;
    localparam int         WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DUMMY_W-1:0] req_dummy = '0;
    logic              stop_req = 1'b0;
    logic              fl_sck, fl_cs_n, fl_dq_oe;
    logic [3:0]        fl_dq_o;
    logic [3:0]        fl_dqa_i = '0;
    logic [3:0]        fl_dqb_i = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [31:0]       out_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_qspi_reader #(
        .ADDR_W (ADDR_W), .DUMMY_W (DUMMY_W), .BUF_DEPTH (DEPTH), .READ_CMD (CMD)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_dummy (req_dummy), .stop_req (stop_req),
        .fl_sck (fl_sck), .fl_cs_n (fl_cs_n), .fl_dq_o (fl_dq_o), .fl_dq_oe (fl_dq_oe),
        .fl_dqa_i (fl_dqa_i), .fl_dqb_i (fl_dqb_i),
        .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // ---------------- two-device flash model ----------------
    int          m_addr, m_dummy;
    int          rises, falls, nib, cs_falls, last_edges;
    bit          streaming, oe_bad;
    logic [31:0] cap;

    function automatic logic [7:0] dev_a(input int k);
        return 8'(k * 3 + 1);
    endfunction

    function automatic logic [7:0] dev_b(input int k);
        return 8'(k) ^ 8'h5A;
    endfunction

    task automatic drive(input int n);
        int k;
        logic [7:0] ba, bb;
        k  = m_addr + n / 2;
        ba = dev_a(k);
        bb = dev_b(k);
        if (n % 2 == 0) begin
            fl_dqa_i = ba[7:4];
            fl_dqb_i = bb[7:4];
        end else begin
            fl_dqa_i = ba[3:0];
            fl_dqb_i = bb[3:0];
        end
    endtask

    always @(negedge fl_cs_n) begin
        rises = 0; falls = 0; nib = 0; streaming = 0; cap = '0;
        cs_falls++;
    end

    always @(posedge fl_cs_n) begin
        last_edges = streaming ? nib : 0;
        streaming  = 0;
        fl_dqa_i   = '0;
        fl_dqb_i   = '0;
    end

    always @(fl_sck) begin
        if (fl_cs_n === 1'b0) begin
            if (fl_sck) begin
                rises++;
                if (rises <= 8) begin
                    cap = {cap[27:0], fl_dq_o};
                    if (!fl_dq_oe) oe_bad = 1;
                end else if (fl_dq_oe) begin
                    oe_bad = 1;
                end
            end else begin
                falls++;
            end
            if (streaming) begin
                nib++;
                drive(nib);
            end else if (!fl_sck && falls == 8 + m_dummy) begin
                streaming = 1;
                nib = 0;
                drive(0);
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [31:0] exp_q[$];
    int          delivered;
    bit          prev_hold;
    logic [31:0] prev_data;

    function automatic logic [31:0] exp_word(input int a, input int j);
        return {dev_b(a + 2*j + 1), dev_a(a + 2*j + 1), dev_b(a + 2*j), dev_a(a + 2*j)};
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_hold)
                check(out_valid && out_data == prev_data, "R7", "held word", out_data, prev_data);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6", "unexpected word", out_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, "R4 R5", "packed word", out_data, e);
                end
                delivered++;
            end
            prev_hold = out_valid && !out_ready;
            prev_data = out_data;
        end
    end

    task automatic start_read(input int a, input int d);
        m_addr = a;
        m_dummy = d;
        oe_bad = 0;
        exp_q.delete();
        for (int j = 0; j < 200; j++) exp_q.push_back(exp_word(a, j));
        delivered = 0;
        req_addr  = ADDR_W'(a);
        req_dummy = DUMMY_W'(d);
        req_valid = 1'b1;
        step();
        req_valid = 1'b0;
    endtask

    task automatic stop_and_drain(input string tag);
        stop_req = 1'b1;
        step();
        stop_req = 1'b0;
        for (int i = 0; i < 100 && !fl_cs_n; i++) step();
        out_ready = 1'b1;
        repeat (2 * DEPTH + 4) step();
        check(fl_cs_n == 1'b1, tag, "chip select released", 32'(fl_cs_n), 32'h1);
        check(last_edges % 4 == 0, "R9", "edges on word boundary", 32'(last_edges % 4), 32'h0);
        check(delivered == last_edges / 4, "R9", "all buffered words delivered",
              32'(delivered), 32'(last_edges / 4));
        check(req_ready && !out_valid, "R9", "back to idle", 32'({req_ready, out_valid}), 32'h2);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int d0, falls0;
        repeat (3) step();
        // R1 reset state
        check(fl_cs_n == 1 && fl_sck == 0, "R1", "cs/sck at reset", 32'({fl_cs_n, fl_sck}), 32'h2);
        check(fl_dq_oe == 0 && out_valid == 0, "R1", "oe/valid at reset", 32'({fl_dq_oe, out_valid}), 32'h0);
        check(req_ready == 1, "R1", "ready at reset", 32'(req_ready), 32'h1);
        rst_n = 1'b1;
        step();

        // Stream with dummy cycles, consumer always ready
        out_ready = 1'b1;
        start_read(32'h012340, 6);
        check(req_ready == 0 && fl_cs_n == 0, "R2", "accepted and selected",
              32'({req_ready, fl_cs_n}), 32'h0);
        repeat (45) step();
        check(cap == {CMD, 24'h012340}, "R2", "command and address", cap, {CMD, 24'h012340});
        check(oe_bad == 0, "R3", "output enable per phase", 32'(oe_bad), 32'h0);
        d0 = delivered;
        repeat (40) step();
        check(delivered - d0 == 10, "R6", "words per 40 clocks", 32'(delivered - d0), 32'd10);
        // R10: request while busy is ignored
        falls0 = cs_falls;
        req_addr = 24'h777777;
        req_valid = 1'b1;
        repeat (5) begin
            check(req_ready == 0, "R10", "not ready while busy", 32'(req_ready), 32'h0);
            step();
        end
        req_valid = 1'b0;
        repeat (20) step();
        check(cs_falls == falls0 && fl_cs_n == 0, "R10", "no restart", 32'(cs_falls), 32'(falls0));
        stop_and_drain("R9");

        // Zero dummy count, intermittent consumer
        start_read(32'h00A5F0, 0);
        for (int i = 0; i < 120; i++) begin
            out_ready = (i % 3 != 0);
            step();
        end
        check(oe_bad == 0, "R3", "zero dummy oe", 32'(oe_bad), 32'h0);
        check(delivered > 20, "R3", "data after zero dummy", 32'(delivered), 32'd21);
        stop_and_drain("R9");

        // Full buffer stalls the flash clock
        out_ready = 1'b0;
        start_read(32'h3C0001, 3);
        repeat (80) step();
        check(out_valid == 1 && fl_cs_n == 0, "R8", "stalled while selected",
              32'({out_valid, fl_cs_n}), 32'h2);
        check(nib == 4 * DEPTH, "R8", "edges before stall", 32'(nib), 32'(4 * DEPTH));
        begin
            int moves;
            logic s0;
            moves = 0;
            s0 = fl_sck;
            for (int i = 0; i < 10; i++) begin
                step();
                if (fl_sck != s0) moves++;
            end
            check(moves == 0 && fl_sck == 0, "R8", "parked clock low", 32'(moves), 32'h0);
        end
        out_ready = 1'b1;
        repeat (40) step();
        check(delivered > DEPTH + 5, "R8", "resumed after stall", 32'(delivered), 32'(DEPTH + 6));
        stop_and_drain("R8");

        // Stop during the preamble
        start_read(32'h000100, 2);
        step();
        stop_and_drain("R9");
        check(delivered == 0 && last_edges == 0, "R9", "no data after early stop",
              32'(delivered), 32'h0);
        check(fl_sck == 0, "R11", "clock low when deselected", 32'(fl_sck), 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule